// File: doc/BRIEF.md
# Bidirectional Pin Port With Masked Output Writes

The block drives a bank of general-purpose pins (32 by default) from a word-wide register interface. Each pin is either driven by its output latch or left floating so an outside source sets its level. The block brings out the output value and a per-pin output-enable, which the pad ring combines into a tri-state buffer. The level seen at each pad is fed back through a two-flop synchroniser and can be read as one word.

Software never needs a read-modify-write to change a single pin. Direction changes through two write-only strobes: one turns the selected pins into outputs and the other turns them back into inputs. Output values are written one half of the port at a time. The upper half of the write word is a per-bit mask that selects which value bits in the lower half are applied. The output latches accept writes while their pins are still inputs, so a driver can load the value first and enable the pin afterwards without a glitch.

Top module: `gpio_mask_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every pin becomes an input (`pin_oe` all 0), every output latch becomes 0 and the synchroniser clears, so a level read returns 0 until new levels pass through it.
- R2: A write to register index 0 sets `pin_oe[k]` for every data bit k that is 1 and leaves the other enable bits unchanged. The new value appears after the clock edge that takes the write.
- R3: A write to register index 1 clears `pin_oe[k]` for every data bit k that is 1 and leaves the other enable bits unchanged.
- R4: A read of index 0 or index 1 returns the current output-enable vector.
- R5: A write to index 2 (low half) sets output latch k, for k below NPIN/2, to data bit k when data bit k+NPIN/2 is 1.
- R6: A write to index 3 (high half) sets output latch k+NPIN/2 to data bit k when data bit k+NPIN/2 is 1.
- R7: In a half write, every latch whose mask bit is 0 keeps its value, and the other half of the port is untouched.
- R8: `pin_out` always shows the output latches, and the latches take writes whether or not their pins are outputs. Writing a value and then enabling the pin drives that value in the first cycle the pin is enabled.
- R9: A read of index 4 returns the pin levels `pin_in` through two register stages: a level present at clock edge n can be read after edge n+1.
- R10: A read of index 2 or 3 returns that half's latches in the low NPIN/2 bits with zeros above. A read of any index above 4 returns 0.
- R11: Writes to index 4 and to indices above 4 change neither `pin_oe` nor `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | NPIN | Write data; for half writes the upper half is the mask |
| rd_idx | input | 3 | Register index of the combinational read |
| rd_data | output | NPIN | Read data for `rd_idx` |
| pin_in | input | NPIN | Level present at each pad |
| pin_out | output | NPIN | Output latch value for each pad |
| pin_oe | output | NPIN | Per-pad output enable, 1 = drive |

## Verification
The bench builds the block with NPIN = 32, so each half is 16 pins and the mask covers bits 31:16. That size reaches every mask position and the boundary between pin 15 and pin 16, where a low write must not touch pin 16 and a high write must not touch pin 15. The bench ties each pad back to `pin_out` while it is enabled and to a bench-driven level otherwise. This makes the two-cycle delay from a latch change to the level read visible, and it makes the preloaded-value-then-enable order visible at the pads.

// File: rtl/gpio_port_pkg.sv
// Package: register index map shared by the pin port, its checker and bench.
// Assumes a word-indexed register space; byte offsets are the integrator's concern.
package gpio_port_pkg;

    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        REG_MAKE_OUT = 3'd0,   // write: 1s turn pins to outputs; read: enable vector
        REG_MAKE_IN  = 3'd1,   // write: 1s turn pins to inputs;  read: enable vector
        REG_DRV_LO   = 3'd2,   // masked write of low-half latches
        REG_DRV_HI   = 3'd3,   // masked write of high-half latches
        REG_LEVEL    = 3'd4    // read: synchronised pad levels
    } reg_idx_e;

endpackage

// File: rtl/gpio_dir_latch.sv
// Module: per-pin output-enable register with separate set and clear strobes.
// Assumes set and clear never arrive in the same cycle (decode guarantees it).
module gpio_dir_latch #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic            clr_en,
    input  logic [NPIN-1:0] bits,
    output logic [NPIN-1:0] oe
);

    // Update enables: OR in on set, mask out on clear, all inputs on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe <= '0;
        end else if (set_en) begin
            oe <= oe | bits;
        end else if (clr_en) begin
            oe <= oe & ~bits;
        end
    end

endmodule

// File: rtl/gpio_drive_half.sv
// Module: one half of the output latches, loaded by a masked write.
// Assumes the write word is twice HALF wide: mask in the upper half, values in the lower.
module gpio_drive_half #(
    parameter int HALF = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2*HALF-1:0] wdata,
    output logic [HALF-1:0]   q
);

    logic [HALF-1:0] mask;
    logic [HALF-1:0] val;

    // Split the write word into its mask and value fields.
    always_comb begin
        mask = wdata[2*HALF-1:HALF];
        val  = wdata[HALF-1:0];
    end

    // Replace only the masked bits; clear all latches on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= (q & ~mask) | (val & mask);
        end
    end

endmodule

// File: rtl/gpio_level_sync.sv
// Module: two-flop synchroniser for the pad levels, one chain per pin.
// Assumes pad inputs may be asynchronous to clk; the depth is fixed at two stages.
module gpio_level_sync #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] d,
    output logic [NPIN-1:0] q
);

    logic [NPIN-1:0] meta;

    // Shift the pad levels through both stages; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/gpio_mask_port.sv
// Module: top of the pin port: write decode, enable and output latches, level
// synchroniser and read mux. Assumes NPIN is even; pads apply pin_oe/pin_out.
module gpio_mask_port
    import gpio_port_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [NPIN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [NPIN-1:0]  rd_data,
    input  logic [NPIN-1:0]  pin_in,
    output logic [NPIN-1:0]  pin_out,
    output logic [NPIN-1:0]  pin_oe
);

    localparam int HALF   = NPIN / 2;
    localparam int NHALVES = 2;

    logic                set_out_we;
    logic                set_in_we;
    logic [NHALVES-1:0]  half_we;
    logic [NPIN-1:0]     level_q;

    // Decode the write index into one strobe per writable register.
    always_comb begin
        set_out_we = wr_en && (reg_idx_e'(wr_idx) == REG_MAKE_OUT);
        set_in_we  = wr_en && (reg_idx_e'(wr_idx) == REG_MAKE_IN);
        half_we[0] = wr_en && (reg_idx_e'(wr_idx) == REG_DRV_LO);
        half_we[1] = wr_en && (reg_idx_e'(wr_idx) == REG_DRV_HI);
    end

    gpio_dir_latch #(.NPIN(NPIN)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_out_we),
        .clr_en (set_in_we),
        .bits   (wr_data),
        .oe     (pin_oe)
    );

    for (genvar h = 0; h < NHALVES; h++) begin : g_half
        gpio_drive_half #(.HALF(HALF)) u_drv (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (half_we[h]),
            .wdata (wr_data),
            .q     (pin_out[h*HALF +: HALF])
        );
    end

    gpio_level_sync #(.NPIN(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (level_q)
    );

    // Select the read word for the addressed register; unmapped reads give 0.
    always_comb begin
        case (reg_idx_e'(rd_idx))
            REG_MAKE_OUT, REG_MAKE_IN: rd_data = pin_oe;
            REG_DRV_LO: rd_data = {{HALF{1'b0}}, pin_out[HALF-1:0]};
            REG_DRV_HI: rd_data = {{HALF{1'b0}}, pin_out[NPIN-1:HALF]};
            REG_LEVEL:  rd_data = level_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mask_port_chk.sv
// Module: assertion checker for gpio_mask_port, attached by bind below.
// Assumes the same NPIN as the instance it watches.
module gpio_mask_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [NPIN-1:0]  wr_data,
    input logic [IDX_W-1:0] rd_idx,
    input logic [NPIN-1:0]  rd_data,
    input logic [NPIN-1:0]  pin_in,
    input logic [NPIN-1:0]  pin_out,
    input logic [NPIN-1:0]  pin_oe
);

    localparam int HALF = NPIN / 2;

    logic [1:0] since_rst;

    // Count edges since reset, saturating once the synchroniser is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0));

    assert_set_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == REG_MAKE_OUT)
        |=> ((pin_oe & $past(wr_data)) == $past(wr_data)));

    assert_set_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == REG_MAKE_IN)
        |=> ((pin_oe & $past(wr_data)) == '0));

    assert_hi_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == REG_DRV_HI)
        |=> ((pin_out[NPIN-1:HALF] & $past(wr_data[NPIN-1:HALF]))
             == ($past(wr_data[HALF-1:0]) & $past(wr_data[NPIN-1:HALF]))));

    assert_lo_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == REG_DRV_LO)
        |=> (((pin_out[HALF-1:0] ^ $past(pin_out[HALF-1:0]))
              & ~$past(wr_data[NPIN-1:HALF])) == '0
             && $stable(pin_out[NPIN-1:HALF])));

    assert_level_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && rd_idx == REG_LEVEL) |-> (rd_data == $past(pin_in, 2)));

    assert_ro_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= REG_LEVEL) |=> ($stable(pin_oe) && $stable(pin_out)));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPIN(NPIN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/tb_gpio_mask_port.sv
// Bench: behavioural per-cycle model of the port, compared on every falling edge.
module tb_gpio_mask_port;
    import gpio_port_pkg::*;

    localparam int NPIN = 32;
    localparam int HALF = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [NPIN-1:0]  wr_data = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [NPIN-1:0]  rd_data;
    logic [NPIN-1:0]  pin_in;
    logic [NPIN-1:0]  pin_out;
    logic [NPIN-1:0]  pin_oe;
    logic [NPIN-1:0]  ext_lvl = '0;

    int n_chk = 0;
    int n_bad = 0;

    // Model state
    logic [NPIN-1:0] m_oe, m_out, m_s1, m_s2;
    bit started = 0;

    always #2 clk = ~clk;

    // Pads: driven pins loop back their own value, others take the bench level.
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

    gpio_mask_port #(.NPIN(NPIN)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Reference model, advanced at each rising edge from its own previous state.
    always @(posedge clk) begin
        logic [NPIN-1:0] lvl;
        logic [NPIN-1:0] nout;
        lvl  = (m_oe & m_out) | (~m_oe & ext_lvl);
        nout = m_out;
        if (!rst_n) begin
            started <= 1;
            m_oe <= '0; m_out <= '0; m_s1 <= '0; m_s2 <= '0;
        end else if (started) begin
            m_s1 <= lvl;
            m_s2 <= m_s1;
            if (wr_en) begin
                if (wr_idx == 3'd0) m_oe <= m_oe | wr_data;
                else if (wr_idx == 3'd1) m_oe <= m_oe & ~wr_data;
                else if (wr_idx == 3'd2 || wr_idx == 3'd3) begin
                    for (int k = 0; k < HALF; k++)
                        if (wr_data[k+HALF])
                            nout[k + (wr_idx == 3'd3 ? HALF : 0)] = wr_data[k];
                    m_out <= nout;
                end
            end
        end
    end

    function automatic logic [NPIN-1:0] exp_rd(logic [IDX_W-1:0] idx);
        case (idx)
            3'd0, 3'd1: return m_oe;
            3'd2: return {16'h0, m_out[HALF-1:0]};
            3'd3: return {16'h0, m_out[NPIN-1:HALF]};
            3'd4: return m_s2;
            default: return '0;
        endcase
    endfunction

    task automatic chk(string tag, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R1 R2 R3 pin_oe", pin_oe, m_oe);
            chk("R1 R5 R6 R7 R8 pin_out", pin_out, m_out);
            case (rd_idx)
                3'd0, 3'd1: chk("R4 rd_data", rd_data, exp_rd(rd_idx));
                3'd4:       chk("R9 rd_data", rd_data, exp_rd(rd_idx));
                default:    chk("R10 rd_data", rd_data, exp_rd(rd_idx));
            endcase
        end
    end

    task automatic put(bit we, logic [2:0] wi, logic [31:0] wd, logic [2:0] ri, logic [31:0] ext);
        @(negedge clk); #1;
        wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri; ext_lvl = ext;
    endtask

    task automatic idle(logic [2:0] ri, int n);
        for (int i = 0; i < n; i++) put(0, 3'd0, 32'h0, ri, ext_lvl);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired R1 act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, with levels present on the pads.
        put(0, 3'd0, 32'h0, 3'd4, 32'hA5A5_5A5A);
        idle(3'd4, 3);
        @(negedge clk); #1; rst_n = 1'b1;
        idle(3'd4, 4);                                  // R9: levels appear after two edges
        // R2: make pins 0..7 and 16 outputs; zeros leave others.
        put(1, 3'd0, 32'h0001_00FF, 3'd0, 32'h0);
        put(1, 3'd0, 32'h0000_0000, 3'd1, 32'h0);
        // R5/R7: low write with partial mask.
        put(1, 3'd2, 32'h00F0_FFFF, 3'd2, 32'h0);
        put(1, 3'd2, 32'h0003_0000, 3'd2, 32'h0);
        // R6: high write; R7: must not touch pin 15.
        put(1, 3'd3, 32'h8001_FFFF, 3'd3, 32'h0);
        idle(3'd4, 3);                                  // R9: loopback seen two cycles later
        // R8: preload pin 20 while input, then enable.
        put(1, 3'd3, 32'h0010_0010, 3'd3, 32'h0);
        put(1, 3'd0, 32'h0010_0000, 3'd0, 32'h0);
        idle(3'd4, 3);
        // R3: back to input for pins 0..3 and 16.
        put(1, 3'd1, 32'h0001_000F, 3'd1, 32'hFFFF_FFFF);
        idle(3'd4, 3);
        // R11: writes to read-only and unmapped indices.
        put(1, 3'd4, 32'hFFFF_FFFF, 3'd5, 32'h1234_5678);
        put(1, 3'd6, 32'hFFFF_FFFF, 3'd6, 32'h1234_5678);
        put(1, 3'd7, 32'hFFFF_FFFF, 3'd7, 32'h1234_5678);
        idle(3'd4, 3);
        // R1: reset in mid-operation.
        @(negedge clk); #1; rst_n = 1'b0;
        idle(3'd0, 2);
        @(negedge clk); #1; rst_n = 1'b1;
        // Mixed traffic covering all requirements.
        for (int i = 0; i < 3000; i++)
            put($urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)), $urandom,
                3'($urandom_range(0, 7)), $urandom);
        idle(3'd4, 4);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule